// File: doc/BRIEF.md
# Folded Linear-Phase FIR Filter

This block is a single-rate, fully parallel FIR filter for coefficient sets that mirror about their centre. Every accepted input sample produces exactly one filtered output. Because the tap at position k and the tap at position NTAPS-1-k carry the same weight, the two samples on those taps are summed in an ordinary adder first. The sum is then multiplied once by the shared weight. For an even tap count this halves the number of multipliers. For an odd tap count, the middle tap has no partner and is multiplied on its own.

The unique weights are written one at a time through a small write port while the stream is idle. A write to index k sets the weight of tap k and also the weight of its mirror tap. The delay line moves forward only on cycles where the input strobe is high. The result keeps full precision: there is no rounding and no truncation. The block is intended for filter chains that need a linear-phase filter at the sample rate and are short of multipliers.

The design has three register stages: the delay line, the pre-adder, and the multiply-and-sum stage. An output-valid flag follows each stage.

Top module: `symfir_top`

## Requirements
- R1: While reset is high and on the first cycle after it is released, out_valid is 0 and out_data is 0. Reset also clears every weight to 0 and every delay-line tap to 0.
- R2: A write with coef_we=1 and coef_addr=k, where k < (NTAPS+1)/2, stores coef_data as the weight of tap k and of tap NTAPS-1-k. Tap 0 holds the newest accepted sample.
- R3: A write whose coef_addr is (NTAPS+1)/2 or greater changes no weight.
- R4: Each output equals the signed sum over j of h(j)·x[n−j] for j from 0 to NTAPS−1. Here x[n] is the newest accepted sample, and samples accepted before reset count as 0.
- R5: Every cycle with in_valid=1 yields exactly one output. out_valid is high in the third cycle after the edge that captured the sample. No output is produced without an accepted sample.
- R6: On cycles where in_valid is 0, the delay line does not move, and the value on in_data has no effect on any later output.
- R7: When NTAPS is odd, the middle tap (index (NTAPS−1)/2) is weighted exactly once. Its unit-impulse response at that position equals its weight, not twice its weight.
- R8: out_data is DATA_W+COEF_W+1+ceil(log2((NTAPS+1)/2)) bits wide and never overflows. With all samples at −2^(DATA_W−1) and all weights at −2^(COEF_W−1), the output is NTAPS·2^(DATA_W+COEF_W−2).
- R9: out_data keeps its value on every cycle where out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Weight write strobe |
| coef_addr | input | ceil(log2(NTAPS)) | Index of the unique weight to write |
| coef_data | input | COEF_W | Signed weight value |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Output result strobe |
| out_data | output | DATA_W+COEF_W+1+ceil(log2((NTAPS+1)/2)) | Signed full-precision filter result |

## Verification
Each fault in internal state shows up at the ports in a predictable way:

- A wrong pairing of mirrored taps, or a centre tap added twice, makes the impulse response asymmetric or doubles its middle value. This is visible within NTAPS outputs of a single impulse.
- A delay line that shifts on idle cycles puts the gap-filler data into the following results. The first output after a gap shows the error.
- A truncated sum width shows up only at the extremes of the input range, so the bench drives full-scale negative and positive runs.
- A miscounted pipeline stage makes out_valid arrive one cycle early or late. This is visible on the very first sample.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

    // number of distinct weights for a mirrored set of taps
    function automatic int uniq_count(input int taps);
        return (taps + 1) / 2;
    endfunction

    // number of mirrored tap pairs that share one multiplier
    function automatic int pair_count(input int taps);
        return taps / 2;
    endfunction

    // growth in bits from summing the given number of products
    function automatic int sum_growth(input int terms);
        return (terms <= 1) ? 0 : $clog2(terms);
    endfunction

endpackage

// File: rtl/symfir_coef_bank.sv
module symfir_coef_bank
    import symfir_pkg::*;
#(
    parameter int NTAPS  = 7,
    parameter int COEF_W = 8,
    parameter int ADDR_W = 3,
    localparam int NUNIQ = uniq_count(NTAPS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [COEF_W-1:0]             wr_data,
    output logic [NUNIQ-1:0][COEF_W-1:0]  h_q
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUNIQ - 1);

    // one register per distinct weight; the mirror tap reads the same one
    for (genvar g = 0; g < NUNIQ; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                h_q[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                h_q[g] <= wr_data;
            end
        end
    end

    // R3: an index past the last distinct weight leaves the bank untouched
    a_r3_oob_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr > LAST_IDX)) |=> $stable(h_q));

endmodule

// File: rtl/symfir_delay_line.sv
module symfir_delay_line #(
    parameter int NTAPS  = 7,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          shift_en,
    input  logic [DATA_W-1:0]             din,
    output logic [NTAPS-1:0][DATA_W-1:0]  taps,
    output logic                          fresh
);

    // tap 0 is the newest sample; the line only moves on an accepted sample
    always_ff @(posedge clk) begin
        if (rst) begin
            taps  <= '0;
            fresh <= 1'b0;
        end else begin
            fresh <= shift_en;
            if (shift_en) begin
                taps <= {taps[NTAPS-2:0], din};
            end
        end
    end

    // R6: an idle strobe keeps every tap where it was
    a_r6_line_frozen: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(taps));

endmodule

// File: rtl/symfir_preadd.sv
module symfir_preadd
    import symfir_pkg::*;
#(
    parameter int NTAPS  = 7,
    parameter int DATA_W = 8,
    localparam int NUNIQ = uniq_count(NTAPS),
    localparam int NPAIR = pair_count(NTAPS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [NTAPS-1:0][DATA_W-1:0]  taps,
    output logic [NUNIQ-1:0][DATA_W:0]    sums,
    output logic                          sums_vld
);

    logic [NUNIQ-1:0][DATA_W:0] sums_d;

    // mirrored pairs are summed one bit wider; an unpaired centre is only sign-extended
    always_comb begin
        for (int k = 0; k < NUNIQ; k++) begin
            if (k < NPAIR) begin
                sums_d[k] = {taps[k][DATA_W-1], taps[k]}
                          + {taps[NTAPS-1-k][DATA_W-1], taps[NTAPS-1-k]};
            end else begin
                sums_d[k] = {taps[k][DATA_W-1], taps[k]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sums     <= '0;
            sums_vld <= 1'b0;
        end else begin
            sums_vld <= en;
            if (en) begin
                sums <= sums_d;
            end
        end
    end

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac #(
    parameter int NUNIQ  = 4,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int ACC_W  = 19
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic [NUNIQ-1:0][DATA_W:0]    sums,
    input  logic [NUNIQ-1:0][COEF_W-1:0]  h,
    output logic [ACC_W-1:0]              acc,
    output logic                          acc_vld
);

    localparam int PROD_W = DATA_W + 1 + COEF_W;

    logic signed [PROD_W-1:0] prod [NUNIQ];
    logic signed [ACC_W-1:0]  total;

    // one multiplier per distinct weight
    always_comb begin
        for (int k = 0; k < NUNIQ; k++) begin
            prod[k] = PROD_W'($signed(sums[k])) * PROD_W'($signed(h[k]));
        end
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < NUNIQ; k++) begin
            total = total + ACC_W'(prod[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            acc_vld <= 1'b0;
        end else begin
            acc_vld <= en;
            if (en) begin
                acc <= total;
            end
        end
    end

endmodule

// File: rtl/symfir_top.sv
module symfir_top
    import symfir_pkg::*;
#(
    parameter int NTAPS  = 7,
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    localparam int NUNIQ  = uniq_count(NTAPS),
    localparam int ADDR_W = (NTAPS <= 2) ? 1 : $clog2(NTAPS),
    localparam int ACC_W  = DATA_W + 1 + COEF_W + sum_growth(NUNIQ)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_we,
    input  logic [ADDR_W-1:0] coef_addr,
    input  logic [COEF_W-1:0] coef_data,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data
);

    logic [NUNIQ-1:0][COEF_W-1:0] h_q;
    logic [NTAPS-1:0][DATA_W-1:0] taps;
    logic                         line_vld;
    logic [NUNIQ-1:0][DATA_W:0]   pair_sums;
    logic                         sums_vld;

    symfir_coef_bank #(
        .NTAPS  (NTAPS),
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coef_we),
        .wr_addr (coef_addr),
        .wr_data (coef_data),
        .h_q     (h_q)
    );

    symfir_delay_line #(
        .NTAPS  (NTAPS),
        .DATA_W (DATA_W)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (in_valid),
        .din      (in_data),
        .taps     (taps),
        .fresh    (line_vld)
    );

    symfir_preadd #(
        .NTAPS  (NTAPS),
        .DATA_W (DATA_W)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .en       (line_vld),
        .taps     (taps),
        .sums     (pair_sums),
        .sums_vld (sums_vld)
    );

    symfir_mac #(
        .NUNIQ  (NUNIQ),
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .en      (sums_vld),
        .sums    (pair_sums),
        .h       (h_q),
        .acc     (out_data),
        .acc_vld (out_valid)
    );

    // R5: an accepted sample comes out three edges later
    a_r5_sample_yields_output: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R5: no output without a sample three edges earlier
    a_r5_no_spurious_output: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    // R9: the result register holds between outputs
    a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/symfir_top_test.sv
`timescale 1ns/1ps
module symfir_top_test;

    localparam int NT = 7;
    localparam int NU = 4;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          coef_we = 1'b0;
    logic [2:0]    coef_addr = '0;
    logic [7:0]    coef_data = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          out_valid;
    logic [AW-1:0] out_data;

    symfir_top uut (
        .clk       (clk),
        .rst       (rst),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2 clk = ~clk;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string req = "R4";

    int hu [NU];
    int hist [NT];
    int q_val [4096];
    int q_due [4096];
    int qr = 0;
    int qw = 0;
    logic [AW-1:0] last_out = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int full_coef(input int j);
        return (j < NU) ? hu[j] : hu[NT - 1 - j];
    endfunction

    task automatic report(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input bit v, input int x);
        int acc;
        @(negedge clk);
        coef_we  = 1'b0;
        in_valid = v;
        in_data  = x[7:0];
        if (v) begin
            for (int j = NT - 1; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = $signed(x[7:0]);
            acc = 0;
            for (int j = 0; j < NT; j++) acc += full_coef(j) * hist[j];
            q_val[qw] = acc;
            q_due[qw] = cyc + 3;
            qw++;
        end
    endtask

    task automatic wcoef(input int a, input int d);
        @(negedge clk);
        in_valid  = 1'b0;
        coef_we   = 1'b1;
        coef_addr = a[2:0];
        coef_data = d[7:0];
        if (a < NU) hu[a] = $signed(d[7:0]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) push(1'b0, $urandom);
    endtask

    task automatic impulse(input int amp);
        push(1'b1, amp);
        for (int i = 0; i < NT; i++) push(1'b1, 0);
        idle(4);
    endtask

    // output monitor: value and arrival cycle against the reference queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (qr == qw) begin
                    report(1'b0, {req, " R5 unexpected output"}, $signed(out_data), 0);
                end else begin
                    report(q_due[qr] == cyc, {req, " R5 latency"}, cyc, q_due[qr]);
                    report($signed(out_data) == q_val[qr], {req, " R4 value"},
                           $signed(out_data), q_val[qr]);
                    qr++;
                end
                last_out = out_data;
            end else begin
                report(out_data == last_out, "R9 hold", $signed(out_data), $signed(last_out));
                if (qr < qw && q_due[qr] == cyc) begin
                    report(1'b0, {req, " R5 missing output"}, 0, q_val[qr]);
                    qr++;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < NU; j++) hu[j] = 0;
        for (int j = 0; j < NT; j++) hist[j] = 0;
        repeat (5) @(negedge clk);
        report(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        report(out_data == '0, "R1 data in reset", $signed(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        report(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        report(out_data == '0, "R1 data after reset", $signed(out_data), 0);
        mon_on = 1'b1;

        // R1: cleared weights give zero output
        req = "R1";
        impulse(77);

        // R2: each write sets a tap and its mirror
        req = "R2";
        wcoef(0, 3); wcoef(1, -5); wcoef(2, 7); wcoef(3, 11);
        impulse(1);

        // R3: out-of-range indices leave the weights alone
        req = "R3";
        wcoef(4, 99); wcoef(5, -99); wcoef(6, 42); wcoef(7, 13);
        impulse(-1);

        // R7: centre weight appears once in the impulse response
        req = "R7";
        wcoef(3, -64);
        impulse(100);

        // R6: gaps carry junk on in_data that must not enter the line
        req = "R6";
        for (int i = 0; i < 120; i++) begin
            if ($urandom_range(0, 2) == 0) push(1'b0, $urandom);
            else push(1'b1, $urandom);
        end
        idle(5);

        // R4: every sample value through random symmetric weights
        for (int s = 0; s < 3; s++) begin
            req = "R4";
            for (int k = 0; k < NU; k++) wcoef(k, $urandom);
            for (int v = -128; v < 128; v++) push(1'b1, v);
            idle(5);
        end

        // R8: full-scale extremes
        req = "R8";
        for (int k = 0; k < NU; k++) wcoef(k, -128);
        for (int i = 0; i < 10; i++) push(1'b1, -128);
        for (int i = 0; i < 10; i++) push(1'b1, 127);
        idle(5);
        report(q_val[qw-11] == 114688, "R8 reference extreme", q_val[qw-11], 114688);

        // R5: every accepted sample has been answered
        idle(4);
        report(qr == qw, "R5 outputs drained", qr, qw);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule